// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block keeps the exception portion of a floating-point status and control register. Every floating-point operation reports a per-instruction flag vector when it completes. The vector carries four ordinary exception conditions (overflow, underflow, divide-by-zero, inexact) and a parameterised set of individual invalid-operation causes, nine by default. The block folds these flags into sticky cause bits. From the cause bits and a set of trap enables it derives an invalid-operation summary and an enabled-exception summary.

The exception-occurred bit (FX) records that an instruction produced an exception that was not already recorded. A start strobe copies the current cause bits into a snapshot. On completion, FX is set when the update qualifier is high and some cause bit is now set that was clear in the snapshot. A summary bit changing is not what decides it, so a second invalid cause under an already-set summary still raises FX. A software write port loads the cause bits, FX and the enables. It is the only way to clear them.

A parameter chooses between summary outputs that follow the cause register in the same cycle and summary outputs taken from a register one cycle later. The default is the same-cycle variant.

Top module: `fpx_status_unit`

## Requirements
- R1: A synchronous active-high reset clears every cause bit, FX and every enable bit to 0.
- R2: On a completion cycle without a software write, the cause vector becomes its previous value ORed with the flag vector, and this is visible after the next clock edge. Vector layout: bit 0 overflow, bit 1 underflow, bit 2 divide-by-zero, bit 3 inexact, bits 4 and up the invalid causes (4 signalling NaN, 5 inf-inf, 6 inf/inf, 7 zero/zero, 8 inf*zero, 9 compare, 10 software, 11 square root, 12 integer convert).
- R3: When the completion strobe is low, the flag vector has no effect: the cause bits keep their value.
- R4: The invalid summary output equals the OR of cause bits 4 and up, and it changes in the same cycle as the cause outputs.
- R5: The enabled-exception summary equals the OR of five terms: invalid summary AND enable bit 0, overflow AND enable bit 1, underflow AND enable bit 2, divide-by-zero AND enable bit 3, inexact AND enable bit 4.
- R6: On completion with the update qualifier high, FX becomes 1 when some cause bit is 1 after the merge and was 0 in the snapshot.
- R7: FX is not set on completion when the update qualifier is low, or when every bit set after the merge was already set in the snapshot.
- R8: The start strobe captures the cause register as it was before that cycle's update, including when start and completion coincide.
- R9: FX is sticky. Only a software write changes it, and writing cause bits through that port never sets FX by itself.
- R10: A software write loads cause bits, FX and enables from its inputs on the next edge and takes priority over a completion in the same cycle, whose flags are then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Instruction start; snapshots the cause bits |
| done_i | input | 1 | Instruction completion; merges flags_i |
| flags_i | input | N_INV+4 | Per-instruction exception flags |
| upd_fx_i | input | 1 | Allows this completion to set FX |
| sw_wr_i | input | 1 | Software write strobe |
| sw_cause_i | input | N_INV+4 | Cause value to write |
| sw_fx_i | input | 1 | FX value to write |
| sw_en_i | input | 5 | Enable value to write |
| cause_o | output | N_INV+4 | Sticky cause bits |
| vx_o | output | 1 | Invalid-operation summary |
| fex_o | output | 1 | Enabled-exception summary |
| fx_o | output | 1 | Exception-occurred bit |
| en_o | output | 5 | Trap enable bits |

## Verification
Cause bits, FX, enables and the snapshot are all one register stage from their inputs. A stimulus driven before an edge therefore shows at the outputs after that edge. With the default parameter, both summaries are combinational from those registers and are due in the same cycle. The bench drives inputs on the falling edge and updates its reference model at once. It compares every output at the following falling edge, which is exactly one rising edge later. The directed cases for coincident start and completion rely on this. The first of them arms FX. A later completion then shows whether the coincident snapshot saw the pre-update value.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   // Number of non-invalid exception conditions held below the invalid causes
   localparam int unsigned NON_INV_W = 4;
   // Default number of individual invalid-operation causes
   localparam int unsigned N_INV_DEF = 9;
   // Trap enables: one for the invalid class plus one per non-invalid condition
   localparam int unsigned EN_W      = NON_INV_W + 1;

   // Positions of the ordinary conditions in the cause vector
   localparam int unsigned C_OVF  = 0;
   localparam int unsigned C_UNF  = 1;
   localparam int unsigned C_DZ   = 2;
   localparam int unsigned C_INX  = 3;

   // Positions in the enable vector
   localparam int unsigned E_INV  = 0;
   localparam int unsigned E_OVF  = 1;

   typedef enum logic [1:0] {
      UPD_HOLD  = 2'd0,
      UPD_MERGE = 2'd1,
      UPD_LOAD  = 2'd2
   } upd_kind_e;
endpackage

// File: rtl/fpx_cause_store.sv
module fpx_cause_store
   import fpx_pkg::*;
#(
   parameter int unsigned CW = NON_INV_W + N_INV_DEF
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic          done_i,
   input  logic [CW-1:0] flags_i,
   input  logic          sw_wr_i,
   input  logic [CW-1:0] sw_cause_i,
   output logic [CW-1:0] cause_q,
   output logic [CW-1:0] snap_q
);
   upd_kind_e     kind;
   logic [CW-1:0] cause_d;

   always_comb begin
      if (sw_wr_i)     kind = UPD_LOAD;
      else if (done_i) kind = UPD_MERGE;
      else             kind = UPD_HOLD;
   end

   always_comb begin
      unique case (kind)
         UPD_LOAD:  cause_d = sw_cause_i;
         UPD_MERGE: cause_d = cause_q | flags_i;
         default:   cause_d = cause_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) cause_q <= '0;
      else     cause_q <= cause_d;
   end

   // Snapshot takes the register value ahead of this cycle's update
   always_ff @(posedge clk) begin
      if (rst)          snap_q <= '0;
      else if (start_i) snap_q <= cause_q;
   end
endmodule

// File: rtl/fpx_fx_track.sv
module fpx_fx_track
   import fpx_pkg::*;
#(
   parameter int unsigned CW = NON_INV_W + N_INV_DEF
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          done_i,
   input  logic          upd_fx_i,
   input  logic [CW-1:0] flags_i,
   input  logic [CW-1:0] cause_q,
   input  logic [CW-1:0] snap_q,
   input  logic          sw_wr_i,
   input  logic          sw_fx_i,
   output logic          fx_q
);
   logic [CW-1:0] merged;
   logic [CW-1:0] fresh;
   logic          raise;

   assign merged = cause_q | flags_i;
   assign fresh  = merged & ~snap_q;
   assign raise  = done_i & upd_fx_i & (|fresh);

   always_ff @(posedge clk) begin
      if (rst)          fx_q <= 1'b0;
      else if (sw_wr_i) fx_q <= sw_fx_i;
      else if (raise)   fx_q <= 1'b1;
   end
endmodule

// File: rtl/fpx_summary.sv
module fpx_summary
   import fpx_pkg::*;
#(
   parameter int unsigned N_INV       = N_INV_DEF,
   parameter bit          REG_SUMMARY = 1'b0,
   localparam int unsigned CW         = NON_INV_W + N_INV
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [CW-1:0]   cause_i,
   input  logic [EN_W-1:0] en_i,
   output logic            vx_o,
   output logic            fex_o
);
   logic vx_c;
   logic fex_c;

   assign vx_c  = |cause_i[CW-1:NON_INV_W];
   assign fex_c = (vx_c & en_i[E_INV]) |
                  (|(cause_i[NON_INV_W-1:0] & en_i[EN_W-1:E_OVF]));

   generate
      if (REG_SUMMARY) begin : g_reg
         logic vx_r;
         logic fex_r;
         always_ff @(posedge clk) begin
            if (rst) begin
               vx_r  <= 1'b0;
               fex_r <= 1'b0;
            end else begin
               vx_r  <= vx_c;
               fex_r <= fex_c;
            end
         end
         assign vx_o  = vx_r;
         assign fex_o = fex_r;
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst;
         assign vx_o  = vx_c;
         assign fex_o = fex_c;
      end
   endgenerate
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
   import fpx_pkg::*;
#(
   parameter int unsigned N_INV       = N_INV_DEF,
   parameter bit          REG_SUMMARY = 1'b0,
   localparam int unsigned CW         = NON_INV_W + N_INV
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start_i,
   input  logic            done_i,
   input  logic [CW-1:0]   flags_i,
   input  logic            upd_fx_i,
   input  logic            sw_wr_i,
   input  logic [CW-1:0]   sw_cause_i,
   input  logic            sw_fx_i,
   input  logic [EN_W-1:0] sw_en_i,
   output logic [CW-1:0]   cause_o,
   output logic            vx_o,
   output logic            fex_o,
   output logic            fx_o,
   output logic [EN_W-1:0] en_o
);
   generate
      if (N_INV < 1) begin : g_bad_ninv
         $error("fpx_status_unit: N_INV must be at least 1");
      end
      if (N_INV > 32) begin : g_big_ninv
         $error("fpx_status_unit: N_INV above 32 is not supported");
      end
   endgenerate

   logic [CW-1:0]   cause_q;
   logic [CW-1:0]   snap_q;
   logic            fx_q;
   logic [EN_W-1:0] en_q;

   fpx_cause_store #(.CW(CW)) u_store (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i),
      .done_i     (done_i),
      .flags_i    (flags_i),
      .sw_wr_i    (sw_wr_i),
      .sw_cause_i (sw_cause_i),
      .cause_q    (cause_q),
      .snap_q     (snap_q)
   );

   fpx_fx_track #(.CW(CW)) u_fx (
      .clk      (clk),
      .rst      (rst),
      .done_i   (done_i & ~sw_wr_i),
      .upd_fx_i (upd_fx_i),
      .flags_i  (flags_i),
      .cause_q  (cause_q),
      .snap_q   (snap_q),
      .sw_wr_i  (sw_wr_i),
      .sw_fx_i  (sw_fx_i),
      .fx_q     (fx_q)
   );

   always_ff @(posedge clk) begin
      if (rst)          en_q <= '0;
      else if (sw_wr_i) en_q <= sw_en_i;
   end

   fpx_summary #(.N_INV(N_INV), .REG_SUMMARY(REG_SUMMARY)) u_sum (
      .clk     (clk),
      .rst     (rst),
      .cause_i (cause_q),
      .en_i    (en_q),
      .vx_o    (vx_o),
      .fex_o   (fex_o)
   );

   assign cause_o = cause_q;
   assign fx_o    = fx_q;
   assign en_o    = en_q;
endmodule

// File: rtl/fpx_status_checker.sv
module fpx_status_checker
   import fpx_pkg::*;
#(
   parameter int unsigned N_INV       = N_INV_DEF,
   parameter bit          REG_SUMMARY = 1'b0,
   localparam int unsigned CW         = NON_INV_W + N_INV
) (
   input logic            clk,
   input logic            rst,
   input logic            done_i,
   input logic            upd_fx_i,
   input logic            sw_wr_i,
   input logic [CW-1:0]   sw_cause_i,
   input logic [EN_W-1:0] sw_en_i,
   input logic [CW-1:0]   cause_o,
   input logic            vx_o,
   input logic            fex_o,
   input logic            fx_o,
   input logic [EN_W-1:0] en_o
);
   assert_clear_R1: assert property (@(posedge clk)
      rst |=> (cause_o == '0) && !fx_o && (en_o == '0));

   assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      !sw_wr_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!done_i && !sw_wr_i) |=> $stable(cause_o));

   generate
      if (!REG_SUMMARY) begin : g_same_cycle
         assert_vx_R4: assert property (@(posedge clk) disable iff (rst)
            vx_o == (|cause_o[CW-1:NON_INV_W]));

         assert_fex_R5: assert property (@(posedge clk) disable iff (rst)
            fex_o == ((vx_o & en_o[E_INV]) |
                      (|(cause_o[NON_INV_W-1:0] & en_o[EN_W-1:E_OVF]))));
      end
   endgenerate

   assert_no_upd_R7: assert property (@(posedge clk) disable iff (rst)
      (!upd_fx_i && !sw_wr_i && !fx_o) |=> !fx_o);

   assert_fx_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (fx_o && !sw_wr_i) |=> fx_o);

   assert_sw_load_R10: assert property (@(posedge clk) disable iff (rst)
      sw_wr_i |=> (cause_o == $past(sw_cause_i)) && (en_o == $past(sw_en_i)));
endmodule

bind fpx_status_unit fpx_status_checker #(
   .N_INV       (N_INV),
   .REG_SUMMARY (REG_SUMMARY)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .done_i     (done_i),
   .upd_fx_i   (upd_fx_i),
   .sw_wr_i    (sw_wr_i),
   .sw_cause_i (sw_cause_i),
   .sw_en_i    (sw_en_i),
   .cause_o    (cause_o),
   .vx_o       (vx_o),
   .fex_o      (fex_o),
   .fx_o       (fx_o),
   .en_o       (en_o)
);

// File: tb/fpx_status_unit_bench.sv
`timescale 1ns/1ps
module fpx_status_unit_bench;
   localparam int CW = 13;
   localparam int EW = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_i = 1'b0;
   logic          done_i = 1'b0;
   logic [CW-1:0] flags_i = '0;
   logic          upd_fx_i = 1'b0;
   logic          sw_wr_i = 1'b0;
   logic [CW-1:0] sw_cause_i = '0;
   logic          sw_fx_i = 1'b0;
   logic [EW-1:0] sw_en_i = '0;
   logic [CW-1:0] cause_o;
   logic          vx_o;
   logic          fex_o;
   logic          fx_o;
   logic [EW-1:0] en_o;

   int checks = 0;
   int fails  = 0;

   logic [CW-1:0] m_cause = '0;
   logic [CW-1:0] m_snap  = '0;
   logic          m_fx    = 1'b0;
   logic [EW-1:0] m_en    = '0;

   always #2.5 clk = ~clk;

   fpx_status_unit u_fpx_status_unit (
      .clk(clk), .rst(rst), .start_i(start_i), .done_i(done_i),
      .flags_i(flags_i), .upd_fx_i(upd_fx_i), .sw_wr_i(sw_wr_i),
      .sw_cause_i(sw_cause_i), .sw_fx_i(sw_fx_i), .sw_en_i(sw_en_i),
      .cause_o(cause_o), .vx_o(vx_o), .fex_o(fex_o), .fx_o(fx_o), .en_o(en_o)
   );

   function automatic logic exp_vx(input logic [CW-1:0] c);
      return |c[CW-1:4];
   endfunction

   function automatic logic exp_fex(input logic [CW-1:0] c, input logic [EW-1:0] e);
      return (exp_vx(c) & e[0]) | (c[0] & e[1]) | (c[1] & e[2]) |
             (c[2] & e[3]) | (c[3] & e[4]);
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Model update for the stimulus currently on the inputs
   task automatic model_step();
      logic [CW-1:0] merged;
      if (rst) begin
         m_cause = '0; m_snap = '0; m_fx = 1'b0; m_en = '0;
      end else begin
         logic [CW-1:0] old_c;
         old_c = m_cause;
         if (sw_wr_i) begin
            m_cause = sw_cause_i; m_fx = sw_fx_i; m_en = sw_en_i;
         end else if (done_i) begin
            merged = m_cause | flags_i;
            if (upd_fx_i && ((merged & ~m_snap) != '0)) m_fx = 1'b1;
            m_cause = merged;
         end
         if (start_i) m_snap = old_c;
      end
   endtask

   // Called at a falling edge: apply stimulus, then compare one edge later
   task automatic step(input string tag, input logic st, input logic dn,
                       input logic [CW-1:0] fl, input logic up,
                       input logic sw, input logic [CW-1:0] swc,
                       input logic swf, input logic [EW-1:0] swe);
      start_i = st; done_i = dn; flags_i = fl; upd_fx_i = up;
      sw_wr_i = sw; sw_cause_i = swc; sw_fx_i = swf; sw_en_i = swe;
      model_step();
      @(negedge clk);
      check(tag, "cause", 32'(cause_o), 32'(m_cause));
      check(tag, "vx",    32'(vx_o),    32'(exp_vx(m_cause)));
      check(tag, "fex",   32'(fex_o),   32'(exp_fex(m_cause, m_en)));
      check(tag, "fx",    32'(fx_o),    32'(m_fx));
      check(tag, "en",    32'(en_o),    32'(m_en));
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, '0, 0, 0, '0, 0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681357));
      @(negedge clk);
      // R1: reset from power-up and after loading everything
      idle("R1"); idle("R1");
      rst = 1'b0;
      step("R10", 0, 0, '0, 0, 1, 13'h1fff, 1, 5'h1f);
      rst = 1'b1;
      idle("R1");
      rst = 1'b0;
      // R3: flags without completion are ignored
      step("R3", 0, 0, 13'h1fff, 1, 0, '0, 0, '0);
      step("R3", 1, 0, 13'h0aaa, 1, 0, '0, 0, '0);
      // R6: new overflow raises FX
      step("R6", 1, 0, '0, 0, 0, '0, 0, 5'h00);
      step("R6", 0, 1, 13'h0001, 1, 0, '0, 0, '0);
      // R9: FX holds, cause write does not set it
      idle("R9");
      step("R9", 0, 0, '0, 0, 1, 13'h0001, 0, 5'h03);
      step("R9", 0, 0, '0, 0, 1, 13'h0021, 0, 5'h03);
      idle("R9");
      // R7: already-set bit does not raise FX; upd low does not either
      step("R7", 1, 0, '0, 0, 0, '0, 0, '0);
      step("R7", 0, 1, 13'h0021, 1, 0, '0, 0, '0);
      step("R7", 0, 1, 13'h0400, 0, 0, '0, 0, '0);
      // R6: second invalid cause while summary already set raises FX
      step("R6", 1, 0, '0, 0, 0, '0, 0, '0);
      step("R6", 0, 1, 13'h0010, 1, 0, '0, 0, '0);
      // R8: coincident start and completion snapshot the pre-update value
      step("R8", 0, 0, '0, 0, 1, '0, 0, 5'h1f);
      step("R8", 1, 0, '0, 0, 0, '0, 0, '0);
      step("R8", 1, 1, 13'h0004, 1, 0, '0, 0, '0);
      step("R8", 0, 0, '0, 0, 1, 13'h0004, 0, 5'h1f);
      step("R8", 0, 1, 13'h0004, 1, 0, '0, 0, '0);
      // R10: write wins over a coincident completion
      step("R10", 0, 1, 13'h1ff0, 1, 1, 13'h0008, 0, 5'h10);
      // R5: enable pairs one at a time
      for (int k = 0; k < 5; k++) begin
         step("R5", 0, 0, '0, 0, 1, 13'h0100 | 13'h000f, 0, 5'(1 << k));
         step("R5", 0, 0, '0, 0, 1, 13'h0000, 0, 5'(1 << k));
      end
      // R2, R4: random mix
      for (int i = 0; i < 3000; i++) begin
         logic sw;
         sw = ($urandom % 16) == 0;
         step(sw ? "R10" : "R2",
              1'($urandom), 1'($urandom),
              CW'($urandom & $urandom & $urandom), 1'($urandom),
              sw, CW'($urandom & $urandom), 1'($urandom), EW'($urandom));
         if (i % 500 == 0) idle("R4");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule